// File: doc/BRIEF.md
# Stereo Digital Volume and Automute Stage

This block processes pairs of 24-bit signed stereo samples on the way from the audio receiver into the interpolation filters. Each accepted pair passes through a per-channel logarithmic attenuator, a digital soft-mute ramp and an optional sign inversion. A zero-run detector watches both channels and engages mute on its own after a long silence.

Control inputs are an 8-bit attenuation code per channel, a mute request, an enable for the zero-run detector, a mode that makes the right channel follow the left attenuation, and a phase-reverse flag. The codes, the follow mode and the phase flag are captured together with each valid sample and govern the samples after it. The mute request acts on the sample that arrives with it. Results appear one clock after the strobe. An active-low flag reports a detected zero run.

Top module: `vms_top`

## Requirements
- R1: The attenuation for code c in 1..255 is (255-c)*0.5 dB. It is applied as an arithmetic right shift by (255-c)/12 combined with multiplication by F/32768, with F = round(32768*10^(-r/40)) and r = (255-c) mod 12. Shifts round toward minus infinity. Code 0xFF passes the sample unchanged.
- R2: Attenuation code 0x00 gives an output of exactly zero for that channel.
- R3: When the follow mode is set, the right channel is scaled with the left channel's attenuation code and the right code is ignored.
- R4: The attenuation codes, the follow mode and the phase flag are captured with each valid sample and apply from the next valid sample onward. Reset values are 0xFF, 0xFF, off and off.
- R5: Outputs are registered. out_valid is high for one clock in the cycle after each in_valid. The output samples hold while no sample arrives, and both are zero after reset.
- R6: While mute is in effect, every valid sample lowers a ramp level that starts at 64 by one, down to 0. The attenuated value is multiplied by level/64 with floor rounding, so the output reaches zero on the 64th muted sample.
- R7: The first valid sample without mute in effect is output at full ramp level (64/64).
- R8: With detection enabled, zero_n goes low in the cycle after the 1024th consecutive valid sample in which both channels are zero. After only 1023 such samples it stays high.
- R9: A valid sample with either channel non-zero clears the latched zero state, so zero_n is high after it. That sample is not subject to automute.
- R10: With detection disabled, zero_n is high and the run count restarts from zero.
- R11: With the phase flag set, output samples are negated, and -8388608 becomes +8388607.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe for one stereo sample pair |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| att_left | input | 8 | Left attenuation code |
| att_right | input | 8 | Right attenuation code |
| mute_req | input | 1 | Soft-mute request |
| zdet_en | input | 1 | Zero-run detector and automute enable |
| att_tie | input | 1 | Right channel follows the left attenuation code |
| phase_rev | input | 1 | Invert the output sign |
| out_valid | output | 1 | Output pair strobe |
| out_left | output | 24 | Processed left sample |
| out_right | output | 24 | Processed right sample |
| zero_n | output | 1 | Low while a zero run is latched |

## Verification
The hardest state to reach from the ports is the boundary of the zero run. The stimulus must deliver exactly 1023 zero pairs and then a non-zero pair, with no silence in between, and separately exactly 1024 zero pairs. A directed sequence builds both runs with the detector enabled, and a random tail mixes in the disabled case. The soft-mute ramp is also driven through all 64 steps. The bench tracks the ramp level independently, so that each intermediate gain is compared and not only the end points.

// File: rtl/vms_pkg.sv
package vms_pkg;

    localparam int FRAC_W    = 16;
    localparam int FRAC_SHIFT = 15;
    localparam int STEP_PER_OCT = 12;

    // fractional gain for the 0.5 dB remainder, Q1.15
    function automatic logic [FRAC_W-1:0] frac_lut(input logic [3:0] rem);
        logic [FRAC_W-1:0] f;
        case (rem)
            4'd0:    f = 16'd32768;
            4'd1:    f = 16'd30935;
            4'd2:    f = 16'd29205;
            4'd3:    f = 16'd27571;
            4'd4:    f = 16'd26029;
            4'd5:    f = 16'd24573;
            4'd6:    f = 16'd23198;
            4'd7:    f = 16'd21900;
            4'd8:    f = 16'd20675;
            4'd9:    f = 16'd19519;
            4'd10:   f = 16'd18427;
            default: f = 16'd17396;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/vms_gain.sv
module vms_gain
    import vms_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CODE_W = 8,
    parameter int LVL_W  = 7,
    parameter int LVL_SH = 6
) (
    input  logic signed [DATA_W-1:0] smp_i,
    input  logic [CODE_W-1:0]        code_i,
    input  logic [LVL_W-1:0]         level_i,
    input  logic                     inv_i,
    output logic signed [DATA_W-1:0] smp_o
);
    localparam int PW = DATA_W + FRAC_W + 1;
    localparam int SW = PW + LVL_W + 2;
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic signed [SW-1:0] POS_LIM = SW'((64'sd1 <<< (DATA_W-1)) - 64'sd1);
    localparam logic signed [SW-1:0] NEG_LIM = SW'(-(64'sd1 <<< (DATA_W-1)));

    logic [CODE_W-1:0]        steps;
    logic [CODE_W-1:0]        oct;
    logic [3:0]               rem;
    logic [FRAC_W-1:0]        frac;
    logic signed [PW-1:0]     prod;
    logic signed [PW-1:0]     shifted;
    logic signed [SW-1:0]     scaled;
    logic signed [SW-1:0]     signed_v;

    always_comb begin
        steps    = CODE_MAX - code_i;
        oct      = steps / CODE_W'(STEP_PER_OCT);
        rem      = 4'(steps % CODE_W'(STEP_PER_OCT));
        frac     = frac_lut(rem);
        prod     = PW'(smp_i) * $signed({1'b0, frac});
        shifted  = prod >>> (FRAC_SHIFT + int'(oct));
        scaled   = (SW'(shifted) * $signed({1'b0, level_i})) >>> LVL_SH;
        signed_v = inv_i ? -scaled : scaled;
        if (code_i == '0) begin
            smp_o = '0;
        end else if (signed_v > POS_LIM) begin
            smp_o = POS_LIM[DATA_W-1:0];
        end else if (signed_v < NEG_LIM) begin
            smp_o = NEG_LIM[DATA_W-1:0];
        end else begin
            smp_o = signed_v[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/vms_ramp.sv
module vms_ramp #(
    parameter int STEPS = 64,
    parameter int LVL_W = $clog2(STEPS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             mute_i,
    output logic [LVL_W-1:0] level_o
);
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(STEPS);

    typedef struct packed {
        logic [LVL_W-1:0] level;
    } ramp_t;

    ramp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            if (!mute_i) begin
                st_d.level = LVL_MAX;
            end else if (st_q.level != '0) begin
                st_d.level = st_q.level - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{level: LVL_MAX};
        else        st_q <= st_d;
    end

    assign level_o = st_d.level;

    // R7
    release_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !mute_i) |=> (st_q.level == LVL_MAX));

    // R6
    ramp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mute_i && st_q.level == '0) |=> (st_q.level == '0));

endmodule

// File: rtl/vms_zero_det.sv
module vms_zero_det #(
    parameter int RUN_LEN = 1024,
    parameter int CNT_W   = $clog2(RUN_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic both_zero_i,
    input  logic enable_i,
    output logic latched_o,
    output logic auto_mute_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             hit;
    } zd_t;

    zd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable_i) begin
            st_d.count = '0;
            st_d.hit   = 1'b0;
        end else if (step_i) begin
            if (!both_zero_i) begin
                st_d.count = '0;
                st_d.hit   = 1'b0;
            end else begin
                if (st_q.count != FULL) st_d.count = st_q.count + 1'b1;
                if (st_q.count >= LAST) st_d.hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latched_o   = st_q.hit;
    assign auto_mute_o = st_q.hit & both_zero_i;

    // R10
    zd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !st_q.hit);

    // R8
    zd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.hit) |-> ($past(st_q.count) == LAST));

endmodule

// File: rtl/vms_top.sv
module vms_top #(
    parameter int DATA_W     = 24,
    parameter int CODE_W     = 8,
    parameter int RAMP_STEPS = 64,
    parameter int ZERO_RUN   = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic [CODE_W-1:0] att_left,
    input  logic [CODE_W-1:0] att_right,
    input  logic              mute_req,
    input  logic              zdet_en,
    input  logic              att_tie,
    input  logic              phase_rev,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              zero_n
);
    localparam int LVL_W  = $clog2(RAMP_STEPS) + 1;
    localparam int LVL_SH = $clog2(RAMP_STEPS);
    localparam int NCH    = 2;

    typedef struct packed {
        logic [CODE_W-1:0] code_l;
        logic [CODE_W-1:0] code_r;
        logic              tie;
        logic              inv;
        logic              valid;
        logic [DATA_W-1:0] out_l;
        logic [DATA_W-1:0] out_r;
    } top_t;

    top_t st_d, st_q;

    logic             both_zero;
    logic             auto_mute;
    logic             zd_latched;
    logic             mute_eff;
    logic [LVL_W-1:0] level;
    logic signed [DATA_W-1:0] ch_in   [NCH];
    logic [CODE_W-1:0]        ch_code [NCH];
    logic signed [DATA_W-1:0] ch_out  [NCH];

    assign both_zero = (in_left == '0) && (in_right == '0);
    assign mute_eff  = mute_req | auto_mute;

    vms_zero_det #(.RUN_LEN(ZERO_RUN)) u_zd (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (in_valid),
        .both_zero_i (both_zero),
        .enable_i    (zdet_en),
        .latched_o   (zd_latched),
        .auto_mute_o (auto_mute)
    );

    vms_ramp #(.STEPS(RAMP_STEPS), .LVL_W(LVL_W)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (in_valid),
        .mute_i  (mute_eff),
        .level_o (level)
    );

    always_comb begin
        ch_in[0]   = $signed(in_left);
        ch_in[1]   = $signed(in_right);
        ch_code[0] = st_q.code_l;
        ch_code[1] = st_q.tie ? st_q.code_l : st_q.code_r;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        vms_gain #(
            .DATA_W (DATA_W),
            .CODE_W (CODE_W),
            .LVL_W  (LVL_W),
            .LVL_SH (LVL_SH)
        ) u_gain (
            .smp_i   (ch_in[g]),
            .code_i  (ch_code[g]),
            .level_i (level),
            .inv_i   (st_q.inv),
            .smp_o   (ch_out[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.out_l  = ch_out[0];
            st_d.out_r  = ch_out[1];
            st_d.code_l = att_left;
            st_d.code_r = att_right;
            st_d.tie    = att_tie;
            st_d.inv    = phase_rev;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.code_l <= {CODE_W{1'b1}};
            st_q.code_r <= {CODE_W{1'b1}};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_left  = st_q.out_l;
    assign out_right = st_q.out_r;
    assign zero_n    = ~zd_latched;

    // R9
    nonzero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_left != '0) |=> zero_n);

    // R2
    zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && st_q.code_l == '0) |=> (out_left == '0));

    // R5
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_left) && $stable(out_right) && !out_valid));

endmodule

// File: tb/vms_top_tb.sv
module vms_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_left = '0, in_right = '0;
    logic [7:0] att_left = 8'hFF, att_right = 8'hFF;
    logic mute_req = 1'b0, zdet_en = 1'b0, att_tie = 1'b0, phase_rev = 1'b0;
    logic out_valid, zero_n;
    logic [DW-1:0] out_left, out_right;

    int n_chk = 0;
    int n_bad = 0;

    // bench model state
    int m_code_l = 255, m_code_r = 255, m_lvl = 64, m_cnt = 0;
    bit m_tie = 0, m_inv = 0, m_am = 0;
    logic [DW-1:0] m_out_l = '0, m_out_r = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vms_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .att_left(att_left), .att_right(att_right),
        .mute_req(mute_req), .zdet_en(zdet_en), .att_tie(att_tie),
        .phase_rev(phase_rev), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right), .zero_n(zero_n)
    );

    function automatic logic [DW-1:0] expect_gain(input logic [DW-1:0] x, input int code,
                                                  input int lvl, input bit inv);
        longint p, a, s;
        int k, fr;
        if (code == 0) return '0;
        k  = 255 - code;
        fr = $rtoi(32768.0 * (10.0 ** (-(k % 12) / 40.0)) + 0.5);
        p  = longint'($signed(x)) * fr;
        a  = p >>> (15 + k / 12);
        s  = (a * lvl) >>> 6;
        if (inv) s = -s;
        if (s > 64'sd8388607) s = 64'sd8388607;
        if (s < -64'sd8388608) s = -64'sd8388608;
        return s[DW-1:0];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
        end
    endtask

    task automatic send(input logic [DW-1:0] l, input logic [DW-1:0] r, input string req);
        bit bz, me;
        int code_r_eff;
        in_valid = 1'b1; in_left = l; in_right = r;
        bz = (l == '0) && (r == '0);
        me = mute_req || (m_am && bz);
        m_lvl = me ? ((m_lvl > 0) ? m_lvl - 1 : 0) : 64;
        code_r_eff = m_tie ? m_code_l : m_code_r;
        m_out_l = expect_gain(l, m_code_l, m_lvl, m_inv);
        m_out_r = expect_gain(r, code_r_eff, m_lvl, m_inv);
        m_code_l = int'(att_left); m_code_r = int'(att_right);
        m_tie = att_tie; m_inv = phase_rev;
        if (!zdet_en || !bz) begin
            m_am = 0; m_cnt = 0;
        end else begin
            if (m_cnt >= 1023) m_am = 1;
            if (m_cnt < 1024) m_cnt++;
        end
        @(posedge clk);
        @(negedge clk);
        check({req, " valid"}, {23'd0, out_valid}, 24'd1);
        check({req, " left"}, out_left, m_out_l);
        check({req, " right"}, out_right, m_out_r);
        check({req, " zero_n"}, {23'd0, zero_n}, {23'd0, ~m_am});
    endtask

    task automatic idle(input string req);
        in_valid = 1'b0;
        in_left = 24'h5A5A5A;
        @(posedge clk);
        @(negedge clk);
        check({req, " idle valid"}, {23'd0, out_valid}, 24'd0);
        check({req, " idle hold"}, out_left, m_out_l);
    endtask

    function automatic logic [DW-1:0] rnd_smp();
        int sel = $urandom_range(0, 7);
        case (sel)
            0: return '0;
            1: return 24'h800000;
            2: return 24'h7FFFFF;
            3: return 24'(int'($urandom_range(0, 20)) - 10);
            default: return 24'($urandom);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 180000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7716));
        repeat (3) @(negedge clk);
        // R5 reset state
        check("R5 reset valid", {23'd0, out_valid}, 24'd0);
        check("R5 reset left", out_left, 24'd0);
        check("R10 reset zero_n", {23'd0, zero_n}, 24'd1);
        rst_n = 1'b1;

        // R1 unity at reset codes
        send(24'h123456, 24'hFEDCBA, "R1 unity");
        send(24'h800000, 24'h7FFFFF, "R1 extremes");
        // R4: new codes apply from next sample
        att_left = 8'hF3; att_right = 8'hFE;
        send(24'h400000, 24'h400000, "R4 old codes");
        send(24'h400000, 24'h400000, "R1 R4 6dB and 0.5dB");
        att_left = 8'h01; att_right = 8'h00;
        send(24'h7FFFFF, 24'h7FFFFF, "R1 mid");
        send(24'h7FFFFF, 24'h7FFFFF, "R1 R2 max atten and zero code");
        // R3 tie
        att_left = 8'hE0; att_right = 8'hFF; att_tie = 1'b1;
        send(24'h300000, 24'h300000, "R3 arm");
        send(24'h300000, 24'hD00000, "R3 tied");
        att_tie = 1'b0;
        send(24'h300000, 24'hD00000, "R3 untie arm");
        send(24'h300000, 24'hD00000, "R3 untied");
        // R11 phase reverse
        att_left = 8'hFF; phase_rev = 1'b1;
        send(24'h000001, 24'h000001, "R11 arm");
        send(24'h800000, 24'h000010, "R11 negate sat");
        phase_rev = 1'b0;
        send(24'h100000, 24'h100000, "R11 off arm");
        idle("R5");
        // R6 ramp down over 64 samples, then R7 release
        mute_req = 1'b1;
        for (int i = 0; i < 66; i++) send(24'h7FFFFF, 24'h812345, "R6 ramp");
        mute_req = 1'b0;
        send(24'h7FFFFF, 24'h812345, "R7 release");
        // R8 R9 zero run
        zdet_en = 1'b1;
        for (int i = 0; i < 1023; i++) send('0, '0, "R8 run");
        send('0, 24'h000001, "R9 break at 1023");
        for (int i = 0; i < 1024; i++) send('0, '0, "R8 run full");
        send('0, '0, "R8 latched");
        idle("R8");
        send(24'h000002, '0, "R9 clear");
        for (int i = 0; i < 1100; i++) send('0, '0, "R8 run again");
        zdet_en = 1'b0;
        send('0, '0, "R10 disable");
        // random
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 9) == 0) att_left = 8'($urandom);
            if ($urandom_range(0, 9) == 0) att_right = 8'($urandom);
            if ($urandom_range(0, 19) == 0) att_tie = ~att_tie;
            if ($urandom_range(0, 19) == 0) phase_rev = ~phase_rev;
            if ($urandom_range(0, 29) == 0) mute_req = ~mute_req;
            if ($urandom_range(0, 49) == 0) zdet_en = ~zdet_en;
            if ($urandom_range(0, 7) == 0) idle("R5 random");
            else send(rnd_smp(), rnd_smp(), "R1 R6 R11 random");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule